// File: doc/BRIEF.md
# Embedded-Sync Video Output Formatter

This block drives an 8-bit interleaved luma/chroma bus, one byte per rising edge of the video clock. Each line carries a start-of-active timing code ahead of the picture and an end-of-active timing code after it. A flag marks every clock that presents a picture byte. Horizontal and vertical sync pins are produced alongside the bus. Their width is programmable and they share one polarity control. For interlaced output, vertical sync both starts and ends at mid-line. Picture data comes from a show-ahead FIFO as one 32-bit group for every four active bytes, and the byte order on the bus is programmable.

Line length, picture window, lines per field, blanking line count and sync widths are all static configuration inputs. Software sets them while the block is in reset. An external stall input lets downstream hardware freeze the stream while a picture byte is on the bus: the byte and the horizontal position stay put and no FIFO group is consumed. During blanking the stall input has no effect, so downstream logic can throttle the output without needing a non-standard clock.

Top module: `vidOutFmt`

## Requirements
- R1: While reset is applied, and after it until the first advance, `vidData` is 00h, `vidActive` is 0, `fifoRd` is 0, and both sync pins sit at their deasserted level.
- R2: Every line, including blanking lines, presents FFh, 00h, 00h, XY on positions `cfgActStart-4` to `cfgActStart-1`. These are the four clocks immediately before the position where `vidActive` rises on picture lines. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H} (bit 7 first), with H=0.
- R3: The sequence FFh, 00h, 00h, XY with H=1 begins on the first clock after the picture window, which is the clock on which `vidActive` falls.
- R4: V in XY is 1 on the first `cfgVblankLines` lines of each field. F in XY is 1 in the even field, which is every second field when `cfgInterlace`=1 and never otherwise.
- R5: Outside the picture window and the code words, the bus carries 80h on chroma positions and 10h on luma positions. A position is chroma when (hPos is even) XOR `cfgLumaFirst`.
- R6: `fifoData` holds Cb in [7:0], Y0 in [15:8], Cr in [23:16] and Y1 in [31:24]. With `cfgLumaFirst`=0 the bus order is Cb,Y0,Cr,Y1. With `cfgLumaFirst`=1 it is Y0,Cb,Y1,Cr. `fifoRd` pulses, with the data taken that same cycle, on the edge that loads the first byte of each group.
- R7: When `holdReq` is 1 at an edge and `vidActive` is 1, the following cycle keeps the same byte, flag, syncs and position, and `fifoRd` stays 0. When `vidActive` is 0, `holdReq` is ignored.
- R8: Horizontal sync is asserted from position 0 of every line for `cfgHsyncLen` clocks.
- R9: With `cfgInterlace`=0, vertical sync is asserted for the first `cfgVsyncLines` lines of each field.
- R10: With `cfgInterlace`=1, vertical sync rises at position `cfgLineLen/2` of the last line of the odd field. It falls at the same position of even-field line `cfgVsyncLines-1`, so it lasts exactly `cfgVsyncLines` lines.
- R11: `cfgSyncLow`=1 makes both sync pins active-low. With 0 they are active-high.
- R12: `vidActive` is 1 exactly on positions `cfgActStart` to `cfgActStart+cfgActLen-1` of the lines that are not vertical blanking lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLineLen | input | H_W | Clocks per line |
| cfgActStart | input | H_W | First picture position (at least 4, even) |
| cfgActLen | input | H_W | Picture bytes per line (multiple of 4) |
| cfgFieldLines | input | V_W | Lines per field |
| cfgVblankLines | input | V_W | Blanking lines at the start of each field |
| cfgHsyncLen | input | H_W | Horizontal sync width in clocks |
| cfgVsyncLines | input | V_W | Vertical sync length in lines (at least 1) |
| cfgInterlace | input | 1 | 1 = alternate odd and even fields |
| cfgLumaFirst | input | 1 | 1 = Y0,Cb,Y1,Cr order |
| cfgSyncLow | input | 1 | 1 = active-low syncs |
| fifoData | input | 32 | Show-ahead FIFO group |
| fifoRd | output | 1 | FIFO pop strobe |
| holdReq | input | 1 | Stall request from downstream |
| vidData | output | 8 | Output byte |
| vidActive | output | 1 | Picture byte present |
| vidHsync | output | 1 | Horizontal sync |
| vidVsync | output | 1 | Vertical sync |

## Verification
The first pattern is progressive, chroma-first, active-high and without stalls. It fixes the placement of the code words, the parity of the blanking fill and the sync windows. The second pattern is interlaced, luma-first and active-low, with random stalls. It separates F-bit and mid-line vertical sync errors from progressive behaviour, and it separates byte reordering from FIFO pop timing under freezing. The third pattern is progressive and luma-first with heavy stalls. It exposes a stall honoured during blanking, and a group popped while frozen.

// File: rtl/vidOutFmtPkg.sv
package vidOutFmtPkg;

  localparam int DATA_W = 8;
  localparam int GRP_W  = 4 * DATA_W;

  typedef enum logic [1:0] {
    SEL_BLANK = 2'd0,
    SEL_CODE  = 2'd1,
    SEL_PEL   = 2'd2
  } byteSel_e;

  // control-to-datapath strobes for the byte loaded at the next advance
  typedef struct packed {
    byteSel_e   sel;
    logic [1:0] idx;          // code word index, or byte lane for a pel
    logic       hBit;
    logic       vBit;
    logic       fBit;
    logic       blankChroma;
    logic       grpLoad;
    logic       hsRaw;
    logic       vsRaw;
    logic       advance;
  } fmtStrobe_t;

  function automatic logic [DATA_W-1:0] xyWord(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vofTiming.sv
module vofTiming
  import vidOutFmtPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] cfgLineLen,
  input  logic [H_W-1:0] cfgActStart,
  input  logic [H_W-1:0] cfgActLen,
  input  logic [V_W-1:0] cfgFieldLines,
  input  logic [V_W-1:0] cfgVblankLines,
  input  logic [H_W-1:0] cfgHsyncLen,
  input  logic [V_W-1:0] cfgVsyncLines,
  input  logic           cfgInterlace,
  input  logic           cfgLumaFirst,
  input  logic           holdReq,
  input  logic           outActive,
  output fmtStrobe_t     strb,
  output logic           fifoRd
);

  localparam logic [H_W-1:0] CODE_LEN = H_W'(4);
  localparam logic [H_W-1:0] H_ONE    = H_W'(1);
  localparam logic [V_W-1:0] V_ONE    = V_W'(1);

  logic [H_W-1:0] hCount;
  logic [V_W-1:0] vCount;
  logic           fieldEven;

  logic [H_W-1:0] savStart, actEnd, halfLine;
  logic           inSav, inEav, inPel, vBlank;
  logic           lastPel, lastLine, advance;
  logic [1:0]     savIdx, eavIdx, pelPhase, pelLane;
  logic           vsProg, vsInter;

  always_comb begin
    savStart = cfgActStart - CODE_LEN;
    actEnd   = cfgActStart + cfgActLen;
    halfLine = cfgLineLen >> 1;
    vBlank   = vCount < cfgVblankLines;
    inSav    = (hCount >= savStart) && (hCount < cfgActStart);
    inEav    = (hCount >= actEnd) && (hCount < actEnd + CODE_LEN);
    inPel    = !vBlank && (hCount >= cfgActStart) && (hCount < actEnd);
    savIdx   = 2'(hCount - savStart);
    eavIdx   = 2'(hCount - actEnd);
    pelPhase = 2'(hCount - cfgActStart);
    pelLane  = cfgLumaFirst ? {pelPhase[1], ~pelPhase[0]} : pelPhase;
    lastPel  = hCount == cfgLineLen - H_ONE;
    lastLine = vCount == cfgFieldLines - V_ONE;
    advance  = !(holdReq && outActive);

    vsProg  = !fieldEven && (vCount < cfgVsyncLines);
    vsInter = (!fieldEven && lastLine && (hCount >= halfLine)) ||
              (fieldEven && ((vCount < cfgVsyncLines - V_ONE) ||
                             ((vCount == cfgVsyncLines - V_ONE) && (hCount < halfLine))));
  end

  always_comb begin
    strb             = '0;
    strb.advance     = advance;
    strb.hBit        = inEav;
    strb.vBit        = vBlank;
    strb.fBit        = fieldEven;
    strb.blankChroma = hCount[0] == cfgLumaFirst;
    strb.hsRaw       = hCount < cfgHsyncLen;
    strb.vsRaw       = cfgInterlace ? vsInter : vsProg;
    if (inSav) begin
      strb.sel = SEL_CODE;
      strb.idx = savIdx;
    end else if (inEav) begin
      strb.sel = SEL_CODE;
      strb.idx = eavIdx;
    end else if (inPel) begin
      strb.sel     = SEL_PEL;
      strb.idx     = pelLane;
      strb.grpLoad = pelPhase == 2'd0;
    end else begin
      strb.sel = SEL_BLANK;
    end
  end

  assign fifoRd = strb.grpLoad && advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      hCount    <= '0;
      vCount    <= '0;
      fieldEven <= 1'b0;
    end else if (advance) begin
      if (lastPel) begin
        hCount <= '0;
        if (lastLine) begin
          vCount    <= '0;
          fieldEven <= cfgInterlace & ~fieldEven;
        end else begin
          vCount <= vCount + V_ONE;
        end
      end else begin
        hCount <= hCount + H_ONE;
      end
    end
  end

endmodule

// File: rtl/vofDatapath.sv
module vofDatapath
  import vidOutFmtPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  fmtStrobe_t        strb,
  input  logic [GRP_W-1:0]  fifoData,
  input  logic              cfgSyncLow,
  output logic [DATA_W-1:0] vidData,
  output logic              vidActive,
  output logic              vidHsync,
  output logic              vidVsync
);

  localparam logic [DATA_W-1:0] FILL_CHROMA = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] FILL_LUMA   = DATA_W'(1) << (DATA_W - 4);

  logic [GRP_W-1:0]  grpReg, grpSrc;
  logic [DATA_W-1:0] dataReg, nextByte;
  logic              activeReg, hsReg, vsReg;

  always_comb begin
    grpSrc = strb.grpLoad ? fifoData : grpReg;
    unique case (strb.sel)
      SEL_CODE: begin
        unique case (strb.idx)
          2'd0:    nextByte = '1;
          2'd3:    nextByte = xyWord(strb.fBit, strb.vBit, strb.hBit);
          default: nextByte = '0;
        endcase
      end
      SEL_PEL:   nextByte = grpSrc[{strb.idx, 3'b000} +: DATA_W];
      default:   nextByte = strb.blankChroma ? FILL_CHROMA : FILL_LUMA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grpReg    <= '0;
      dataReg   <= '0;
      activeReg <= 1'b0;
      hsReg     <= 1'b0;
      vsReg     <= 1'b0;
    end else if (strb.advance) begin
      if (strb.grpLoad) grpReg <= fifoData;
      dataReg   <= nextByte;
      activeReg <= strb.sel == SEL_PEL;
      hsReg     <= strb.hsRaw;
      vsReg     <= strb.vsRaw;
    end
  end

  assign vidData   = dataReg;
  assign vidActive = activeReg;
  assign vidHsync  = hsReg ^ cfgSyncLow;
  assign vidVsync  = vsReg ^ cfgSyncLow;

endmodule

// File: rtl/vidOutFmt.sv
module vidOutFmt
  import vidOutFmtPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [H_W-1:0]    cfgLineLen,
  input  logic [H_W-1:0]    cfgActStart,
  input  logic [H_W-1:0]    cfgActLen,
  input  logic [V_W-1:0]    cfgFieldLines,
  input  logic [V_W-1:0]    cfgVblankLines,
  input  logic [H_W-1:0]    cfgHsyncLen,
  input  logic [V_W-1:0]    cfgVsyncLines,
  input  logic              cfgInterlace,
  input  logic              cfgLumaFirst,
  input  logic              cfgSyncLow,
  input  logic [GRP_W-1:0]  fifoData,
  output logic              fifoRd,
  input  logic              holdReq,
  output logic [DATA_W-1:0] vidData,
  output logic              vidActive,
  output logic              vidHsync,
  output logic              vidVsync
);

  fmtStrobe_t strb;

  vofTiming #(.H_W(H_W), .V_W(V_W)) u_timing (
    .clk(clk), .rst(rst),
    .cfgLineLen(cfgLineLen), .cfgActStart(cfgActStart), .cfgActLen(cfgActLen),
    .cfgFieldLines(cfgFieldLines), .cfgVblankLines(cfgVblankLines),
    .cfgHsyncLen(cfgHsyncLen), .cfgVsyncLines(cfgVsyncLines),
    .cfgInterlace(cfgInterlace), .cfgLumaFirst(cfgLumaFirst),
    .holdReq(holdReq), .outActive(vidActive),
    .strb(strb), .fifoRd(fifoRd)
  );

  vofDatapath u_datapath (
    .clk(clk), .rst(rst), .strb(strb), .fifoData(fifoData),
    .cfgSyncLow(cfgSyncLow),
    .vidData(vidData), .vidActive(vidActive),
    .vidHsync(vidHsync), .vidVsync(vidVsync)
  );

endmodule

// File: rtl/vidOutFmtChk.sv
module vidOutFmtChk (
  input logic       clk,
  input logic       rst,
  input logic       holdReq,
  input logic       fifoRd,
  input logic [7:0] vidData,
  input logic       vidActive
);

  AST_SAV_LEAD: assert property (@(posedge clk) disable iff (rst)
    $rose(vidActive) |-> $past(vidData, 4) == 8'hFF); // R2

  AST_EAV_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(vidActive) |-> vidData == 8'hFF); // R3

  AST_POP_FEEDS_PEL: assert property (@(posedge clk) disable iff (rst)
    fifoRd |=> vidActive); // R6

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (holdReq && vidActive) |=> ($stable(vidData) && vidActive)); // R7

  AST_NO_POP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (holdReq && vidActive) |-> !fifoRd); // R7

endmodule

bind vidOutFmt vidOutFmtChk u_chk (
  .clk(clk), .rst(rst), .holdReq(holdReq), .fifoRd(fifoRd),
  .vidData(vidData), .vidActive(vidActive)
);

// File: tb/vidOutFmt_tb.sv
module vidOutFmt_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        holdReq = 1'b0;
  logic [31:0] fifoData;
  logic        fifoRd;
  logic [7:0]  vidData;
  logic        vidActive, vidHsync, vidVsync;

  int LL = 40, AS = 12, AL = 16, FL = 8, VB = 2, HS = 5, VS = 3;
  int ilace = 0, lumaFirst = 0, syncLow = 0;

  int nChk = 0, nFail = 0, gDrv = 0;

  // reference model state
  int h, v, f, grp, curGrp;
  int expData, expActive, expHs, expVs;
  bit lastStall;
  string tagData;

  always #2 clk = ~clk;

  always_comb fifoData = {8'(gDrv*4+3), 8'(gDrv*4+2), 8'(gDrv*4+1), 8'(gDrv*4)};

  always @(posedge clk) begin
    if (rst) gDrv <= 0;
    else if (fifoRd) gDrv <= gDrv + 1;
  end

  vidOutFmt u_dut (
    .clk(clk), .rst(rst),
    .cfgLineLen(12'(LL)), .cfgActStart(12'(AS)), .cfgActLen(12'(AL)),
    .cfgFieldLines(11'(FL)), .cfgVblankLines(11'(VB)),
    .cfgHsyncLen(12'(HS)), .cfgVsyncLines(11'(VS)),
    .cfgInterlace(ilace[0]), .cfgLumaFirst(lumaFirst[0]), .cfgSyncLow(syncLow[0]),
    .fifoData(fifoData), .fifoRd(fifoRd), .holdReq(holdReq),
    .vidData(vidData), .vidActive(vidActive), .vidHsync(vidHsync), .vidVsync(vidVsync)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d f=%0d)", tag, act, exp, h, v, f);
    end
  endtask

  function automatic int codeByte(int k, int fb, int vb, int hb);
    if (k == 0) return 8'hFF;
    if (k < 3) return 0;
    return 128 + fb*64 + vb*32 + hb*16 + (vb^hb)*8 + (fb^hb)*4 + (fb^vb)*2 + (fb^vb^hb);
  endfunction

  task automatic modelReset();
    h = 0; v = 0; f = 0; grp = 0; curGrp = 0;
    expData = 0; expActive = 0; expHs = 0; expVs = 0;
    lastStall = 0; tagData = "R1";
  endtask

  task automatic modelStep();
    int vb, ph, idx, half;
    lastStall = holdReq && (expActive != 0);
    if (lastStall) return;
    half = LL / 2;
    vb = (v < VB) ? 1 : 0;
    expHs = (h < HS) ? 1 : 0;
    if (ilace == 0) expVs = (v < VS) ? 1 : 0;
    else expVs = ((f == 0 && v == FL-1 && h >= half) ||
                  (f == 1 && (v < VS-1 || (v == VS-1 && h < half)))) ? 1 : 0;
    expActive = 0;
    if (h >= AS-4 && h < AS) begin
      expData = codeByte(h-(AS-4), f, vb, 0);
      tagData = (h == AS-1) ? "R4" : "R2";
    end else if (h >= AS+AL && h < AS+AL+4) begin
      expData = codeByte(h-(AS+AL), f, vb, 1);
      tagData = (h == AS+AL+3) ? "R4" : "R3";
    end else if (vb == 0 && h >= AS && h < AS+AL) begin
      expActive = 1;
      ph = (h - AS) % 4;
      if (ph == 0) begin curGrp = grp; grp++; end
      if (lumaFirst != 0) idx = (ph == 0) ? 1 : (ph == 1) ? 0 : (ph == 2) ? 3 : 2;
      else idx = ph;
      expData = (curGrp*4 + idx) & 255;
      tagData = "R6";
    end else begin
      expData = ((((h % 2) == 0) ? 1 : 0) ^ lumaFirst) != 0 ? 8'h80 : 8'h10;
      tagData = "R5";
    end
    h++;
    if (h == LL) begin
      h = 0; v++;
      if (v == FL) begin v = 0; f = (ilace != 0) ? 1 - f : 0; end
    end
  endtask

  always @(posedge clk) begin
    if (rst) modelReset();
    else modelStep();
  end

  task automatic compareOutputs();
    chk(lastStall ? "R7" : tagData, vidData, expData);
    chk(lastStall ? "R7" : "R12", vidActive, expActive);
    chk(syncLow != 0 ? "R11" : "R8", vidHsync, expHs ^ syncLow);
    chk(ilace != 0 ? "R10" : "R9", vidVsync, expVs ^ syncLow);
  endtask

  task automatic runPhase(int il, int lf, int sl, int pct, int cycles);
    int expRd;
    rst = 1'b1; holdReq = 1'b0;
    ilace = il; lumaFirst = lf; syncLow = sl;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", vidData, 0);
    chk("R1", vidActive, 0);
    chk("R1", vidHsync, sl);
    chk("R1", vidVsync, sl);
    chk("R1", fifoRd, 0);
    rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compareOutputs();
      holdReq = (pct > 0) && ($urandom_range(99) < pct);
      #1;
      expRd = ((v >= VB) && h >= AS && h < AS+AL && ((h-AS) % 4) == 0 &&
               !(holdReq && expActive != 0)) ? 1 : 0;
      chk(holdReq && expActive != 0 ? "R7" : "R6", fifoRd, expRd);
    end
  endtask

  initial begin
    #(4*150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    runPhase(0, 0, 0, 0, 700);    // progressive, chroma first, active-high
    runPhase(1, 1, 1, 30, 1600);  // interlaced, luma first, active-low, stalls
    runPhase(0, 1, 0, 55, 900);   // progressive, luma first, heavy stalls
    runPhase(1, 0, 0, 10, 1400);  // interlaced, chroma first, light stalls
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule